// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block holds a bank of independent capture/compare channels that sit beside a shared timer counter. The counter is outside the block. Its current value and a one-cycle strobe that marks each count update come in as inputs. Each channel is set by a 3-bit mode field.

In capture mode, a channel watches its input pin. The pin passes through a synchroniser first. When the selected edge arrives, the channel stores the current count. In compare mode, a channel checks the count against its stored value on every count update. On a match it sets, clears or toggles its output pin.

Every capture or compare event does two things. It sets a sticky interrupt flag for that channel, which software clears by writing a one to it. It also sends a one-cycle pulse that can trigger a DMA transfer. Software loads each channel's mode and value through per-channel write strobes. It reads back any channel's value through a select input.

Top module: `tmr_ccu`

## Requirements
- R1: After reset, all modes are 0 (disabled), all channel values are 0, and every output pin, interrupt flag and DMA pulse is low.
- R2: The mode codes are: 0 disabled, 1 capture on rising edge, 2 capture on falling edge, 3 capture on either edge, 4 compare-set, 5 compare-clear, 6 compare-toggle. Code 7 acts as disabled. A disabled channel produces no event.
- R3: A pin level that is first sampled at clock edge k is seen by the edge detector two cycles later. A matching edge makes the channel store the `tmr_cnt` value present at edge k+2, and the event is visible after edge k+2.
- R4: In a compare mode, a clock edge with `tmr_tick` high and `tmr_cnt` equal to the channel value changes the output pin at that edge. Mode 4 drives it high, mode 5 drives it low, and mode 6 inverts it.
- R5: While `tmr_tick` is low, no compare action occurs, even if the count equals the channel value.
- R6: Each event sets that channel's interrupt flag at the same edge. The flag stays set until it is cleared.
- R7: A one in bit i of `irq_clr` clears flag i at the next edge. If an event on channel i happens in the same cycle, the flag stays set.
- R8: Each event produces exactly one cycle of `dma_trig` high for that channel, aligned with the edge that sets the flag.
- R9: `val_we[i]` loads `val_wdata` into channel i. If a capture happens in the same cycle, the write wins. `rd_val` shows the value of channel `rd_sel`, and reads 0 when `rd_sel` is not below the channel count.
- R10: Channels act independently. An event, write or clear on one channel changes no other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_cnt | input | 16 | Current timer count |
| tmr_tick | input | 1 | High for one cycle when the count has just updated |
| mode_we | input | 5 | Per-channel mode write strobe |
| mode_wdata | input | 3 | Mode code to write |
| val_we | input | 5 | Per-channel value write strobe |
| val_wdata | input | 16 | Capture/compare value to write |
| rd_sel | input | 3 | Channel whose value appears on rd_val |
| rd_val | output | 16 | Value of the selected channel |
| cap_in | input | 5 | Channel input pins (asynchronous) |
| cmp_out | output | 5 | Channel output pins |
| irq_clr | input | 5 | Write-one-to-clear for the interrupt flags |
| irq_flag | output | 5 | Sticky per-channel interrupt flags |
| dma_trig | output | 5 | One-cycle per-channel event pulses |

## Verification
Directed cases come first. One moves the count on each of the three cycles after a pin edge, so only the two-cycle synchroniser latency stores the third value. Another holds count equal to the compare value with the strobe low, then raises the strobe, which separates match-on-update from match-on-equality. Others pair a clear with a simultaneous event, a value write with a simultaneous capture, mode code 7 with live pins, and an out-of-range read select. After that, random cycles mix pin toggles, strobes, counts drawn from the channels' own values, mode rewrites and clears across all channels. A bench model is compared every cycle, and this exposes any crosstalk between channels and any wrong action for a given mode.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      CCM_OFF      = 3'd0,
      CCM_CAP_RISE = 3'd1,
      CCM_CAP_FALL = 3'd2,
      CCM_CAP_BOTH = 3'd3,
      CCM_CMP_SET  = 3'd4,
      CCM_CMP_CLR  = 3'd5,
      CCM_CMP_TGL  = 3'd6,
      CCM_RSVD     = 3'd7
   } ccm_mode_e;
endpackage

// File: rtl/tmr_ccu_sync.sv
module tmr_ccu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_ccu_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_ccu_chan.sv
module tmr_ccu_chan
   import tmr_ccu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tmr_cnt,
   input  logic              tmr_tick,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              val_we,
   input  logic [CNT_W-1:0]  val_wdata,
   input  logic              pin_in,
   input  logic              irq_clr,
   output logic [CNT_W-1:0]  val_o,
   output logic              pin_out,
   output logic              irq_o,
   output logic              dma_o
);
   ccm_mode_e        mode_q;
   logic [CNT_W-1:0] val_q;
   logic             pin_s, pin_prev_q;
   logic             rise, fall, cap_evt, cmp_hit, evt;

   tmr_ccu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_s)
   );

   assign rise = pin_s & ~pin_prev_q;
   assign fall = ~pin_s & pin_prev_q;

   always_comb begin
      cap_evt = 1'b0;
      cmp_hit = 1'b0;
      unique case (mode_q)
         CCM_CAP_RISE: cap_evt = rise;
         CCM_CAP_FALL: cap_evt = fall;
         CCM_CAP_BOTH: cap_evt = rise | fall;
         CCM_CMP_SET, CCM_CMP_CLR, CCM_CMP_TGL:
            cmp_hit = tmr_tick && (tmr_cnt == val_q);
         default: ;
      endcase
   end

   assign evt = cap_evt | cmp_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= CCM_OFF;
         val_q      <= '0;
         pin_prev_q <= 1'b0;
         pin_out    <= 1'b0;
         irq_o      <= 1'b0;
         dma_o      <= 1'b0;
      end else begin
         pin_prev_q <= pin_s;
         dma_o      <= evt;
         if (mode_we) mode_q <= ccm_mode_e'(mode_wdata);
         if (val_we)       val_q <= val_wdata;
         else if (cap_evt) val_q <= tmr_cnt;
         if (cmp_hit) begin
            unique case (mode_q)
               CCM_CMP_SET: pin_out <= 1'b1;
               CCM_CMP_CLR: pin_out <= 1'b0;
               default:     pin_out <= ~pin_out;
            endcase
         end
         if (evt)          irq_o <= 1'b1;
         else if (irq_clr) irq_o <= 1'b0;
      end
   end

   assign val_o = val_q;

   // R8
   dma_flag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_o |-> irq_o);
   // R5
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_tick |=> $stable(pin_out));
   // R4
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && tmr_cnt == val_q && mode_q == CCM_CMP_TGL) |=> (pin_out != $past(pin_out)));
   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> (!irq_o || dma_o));
   // R6
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr) |=> irq_o);
   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CCM_OFF || mode_q == CCM_RSVD) |=> !dma_o);
   // R9
   val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !val_we |=> (dma_o || $stable(val_q)));
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
   import tmr_ccu_pkg::*;
#(
   parameter int NUM_CH      = 5,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tmr_cnt,
   input  logic              tmr_tick,
   input  logic [NUM_CH-1:0] mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [NUM_CH-1:0] val_we,
   input  logic [CNT_W-1:0]  val_wdata,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [CNT_W-1:0]  rd_val,
   input  logic [NUM_CH-1:0] cap_in,
   output logic [NUM_CH-1:0] cmp_out,
   input  logic [NUM_CH-1:0] irq_clr,
   output logic [NUM_CH-1:0] irq_flag,
   output logic [NUM_CH-1:0] dma_trig
);
   logic [CNT_W-1:0] val_arr [NUM_CH];

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
         $error("tmr_ccu: NUM_CH must be within 1..16");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("tmr_ccu: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_ccu: SYNC_STAGES must be at least 2");
      end

      for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
         tmr_ccu_chan #(
            .CNT_W      (CNT_W),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tmr_cnt   (tmr_cnt),
            .tmr_tick  (tmr_tick),
            .mode_we   (mode_we[gi]),
            .mode_wdata(mode_wdata),
            .val_we    (val_we[gi]),
            .val_wdata (val_wdata),
            .pin_in    (cap_in[gi]),
            .irq_clr   (irq_clr[gi]),
            .val_o     (val_arr[gi]),
            .pin_out   (cmp_out[gi]),
            .irq_o     (irq_flag[gi]),
            .dma_o     (dma_trig[gi])
         );
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_sel == SEL_W'(i)) rd_val = val_arr[i];
      end
   end
endmodule

// File: tb/tmr_ccu_tb.sv
`timescale 1ns/1ps
module tmr_ccu_tb;
   localparam int NCH = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tmr_cnt = '0;
   logic        tmr_tick = 1'b0;
   logic [4:0]  mode_we = '0;
   logic [2:0]  mode_wdata = '0;
   logic [4:0]  val_we = '0;
   logic [15:0] val_wdata = '0;
   logic [2:0]  rd_sel = '0;
   logic [15:0] rd_val;
   logic [4:0]  cap_in = '0;
   logic [4:0]  cmp_out;
   logic [4:0]  irq_clr = '0;
   logic [4:0]  irq_flag;
   logic [4:0]  dma_trig;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] m_val  [NCH];
   logic [2:0]  m_mode [NCH];
   logic        m_out  [NCH];
   logic        m_flag [NCH];
   logic        m_dma  [NCH];
   logic        p1 [NCH];
   logic        p2 [NCH];
   logic        p3 [NCH];

   always #4 clk = ~clk;

   tmr_ccu u_dut (
      .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_tick(tmr_tick),
      .mode_we(mode_we), .mode_wdata(mode_wdata), .val_we(val_we),
      .val_wdata(val_wdata), .rd_sel(rd_sel), .rd_val(rd_val),
      .cap_in(cap_in), .cmp_out(cmp_out), .irq_clr(irq_clr),
      .irq_flag(irq_flag), .dma_trig(dma_trig)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [2:0] sel);
      return (sel < 3'(NCH)) ? m_val[sel] : 16'h0;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_val[c] = '0; m_mode[c] = '0; m_out[c] = 1'b0; m_flag[c] = 1'b0;
         m_dma[c] = 1'b0; p1[c] = 1'b0; p2[c] = 1'b0; p3[c] = 1'b0;
      end
   endtask

   // Model update per the requirements, evaluated with the inputs held at the edge.
   task automatic model_edge();
      for (int c = 0; c < NCH; c++) begin
         logic rise, fall, cap, hit;
         rise = p2[c] & ~p3[c];
         fall = ~p2[c] & p3[c];
         cap  = (m_mode[c] == 3'd1 && rise) || (m_mode[c] == 3'd2 && fall) ||
                (m_mode[c] == 3'd3 && (rise || fall));
         hit  = tmr_tick && (tmr_cnt == m_val[c]) && (m_mode[c] >= 3'd4) && (m_mode[c] <= 3'd6);
         if (hit) begin
            if (m_mode[c] == 3'd4)      m_out[c] = 1'b1;
            else if (m_mode[c] == 3'd5) m_out[c] = 1'b0;
            else                        m_out[c] = ~m_out[c];
         end
         if (val_we[c]) m_val[c] = val_wdata;
         else if (cap)  m_val[c] = tmr_cnt;
         if (cap || hit)      m_flag[c] = 1'b1;
         else if (irq_clr[c]) m_flag[c] = 1'b0;
         m_dma[c] = cap || hit;
         if (mode_we[c]) m_mode[c] = mode_wdata;
         p3[c] = p2[c]; p2[c] = p1[c]; p1[c] = cap_in[c];
      end
   endtask

   task automatic compare_all();
      for (int c = 0; c < NCH; c++) begin
         chk(cmp_out[c] == m_out[c],   "R4 cmp_out",  16'(cmp_out[c]),  16'(m_out[c]));
         chk(irq_flag[c] == m_flag[c], "R6 irq_flag", 16'(irq_flag[c]), 16'(m_flag[c]));
         chk(dma_trig[c] == m_dma[c],  "R8 dma_trig", 16'(dma_trig[c]), 16'(m_dma[c]));
      end
      chk(rd_val == exp_rd(rd_sel), "R9 rd_val", rd_val, exp_rd(rd_sel));
   endtask

   // one clock: inputs already set at the negedge; check at the following negedge
   task automatic cycle();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      mode_we = '0; val_we = '0; irq_clr = '0; tmr_tick = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h1c0ffee);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(cmp_out == 5'b0 && irq_flag == 5'b0 && dma_trig == 5'b0, "R1 outputs",
          {1'b0, cmp_out, irq_flag, dma_trig}, 16'h0);
      chk(rd_val == 16'h0, "R1 value", rd_val, 16'h0);
      rst_n = 1'b1;

      // R3 capture latency: ch0 rising edge, count moves on each cycle
      mode_we = 5'b00001; mode_wdata = 3'd1; cycle(); idle();
      cap_in[0] = 1'b1; tmr_cnt = 16'h1111; cycle();
      chk(irq_flag[0] == 1'b0, "R3 early edge k", 16'(irq_flag[0]), 16'h0);
      tmr_cnt = 16'h2222; cycle();
      chk(irq_flag[0] == 1'b0, "R3 early edge k+1", 16'(irq_flag[0]), 16'h0);
      tmr_cnt = 16'h3333; rd_sel = 3'd0; cycle();
      chk(irq_flag[0] == 1'b1 && dma_trig[0] == 1'b1, "R3 event at k+2",
          {14'h0, irq_flag[0], dma_trig[0]}, 16'h3);
      chk(rd_val == 16'h3333, "R3 captured count", rd_val, 16'h3333);
      cycle();
      chk(dma_trig[0] == 1'b0, "R8 single pulse", 16'(dma_trig[0]), 16'h0);

      // R5 / R4 compare toggle on ch1
      mode_we = 5'b00010; mode_wdata = 3'd6; val_we = 5'b00010; val_wdata = 16'h0040; cycle(); idle();
      tmr_cnt = 16'h0040; cycle(); cycle();
      chk(cmp_out[1] == 1'b0, "R5 equal without tick", 16'(cmp_out[1]), 16'h0);
      tmr_tick = 1'b1; cycle(); tmr_tick = 1'b0;
      chk(cmp_out[1] == 1'b1, "R4 toggle on match", 16'(cmp_out[1]), 16'h1);
      cycle();
      chk(cmp_out[1] == 1'b1, "R5 hold after tick", 16'(cmp_out[1]), 16'h1);

      // R7 clear collides with an event: event wins; then plain clear
      tmr_tick = 1'b1; irq_clr = 5'b00010; cycle(); idle();
      chk(irq_flag[1] == 1'b1, "R7 event beats clear", 16'(irq_flag[1]), 16'h1);
      irq_clr = 5'b00010; cycle(); idle();
      chk(irq_flag[1] == 1'b0, "R7 clear", 16'(irq_flag[1]), 16'h0);
      chk(irq_flag[0] == 1'b1, "R10 other flag kept", 16'(irq_flag[0]), 16'h1);

      // R2 code 7 behaves as disabled
      mode_we = 5'b00100; mode_wdata = 3'd7; cycle(); idle();
      tmr_cnt = 16'h0000; tmr_tick = 1'b1; cap_in[2] = 1'b1; cycle(); idle();
      repeat (3) cycle();
      chk(irq_flag[2] == 1'b0, "R2 reserved code quiet", 16'(irq_flag[2]), 16'h0);

      // R9 out-of-range select and write beating capture on ch0 (either edge)
      rd_sel = 3'd7; cycle();
      chk(rd_val == 16'h0, "R9 out of range read", rd_val, 16'h0);
      mode_we = 5'b00001; mode_wdata = 3'd3; cycle(); idle();
      cap_in[0] = 1'b0; tmr_cnt = 16'h7777; cycle(); cycle();
      val_we = 5'b00001; val_wdata = 16'hABCD; rd_sel = 3'd0; cycle(); idle();
      chk(rd_val == 16'hABCD, "R9 write beats capture", rd_val, 16'hABCD);
      chk(dma_trig[0] == 1'b1, "R3 falling capture event", 16'(dma_trig[0]), 16'h1);

      // R10 random mix across all channels
      for (int it = 0; it < 4000; it++) begin
         tmr_tick = ($urandom % 3) == 0;
         if ($urandom % 2 == 0) tmr_cnt = m_val[$urandom % NCH];
         else                   tmr_cnt = 16'($urandom);
         if ($urandom % 4 == 0) cap_in = cap_in ^ 5'($urandom);
         mode_we    = ($urandom % 12 == 0) ? 5'(1 << ($urandom % NCH)) : 5'b0;
         mode_wdata = 3'($urandom);
         val_we     = ($urandom % 16 == 0) ? 5'(1 << ($urandom % NCH)) : 5'b0;
         val_wdata  = 16'($urandom % 64);
         irq_clr    = ($urandom % 6 == 0) ? 5'($urandom) : 5'b0;
         rd_sel     = 3'($urandom);
         cycle();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule